// File: doc/BRIEF.md
# Trap Return Privilege Update Unit

This block holds the privilege-related state of one hart: the current privilege level, the guest (virtualized) flag, the interrupt-enable bits, and the saved context that a trap leaves behind. The saved context is the prior enables, the prior privileges and the prior guest flags. A second-level stash of guest flag and privilege is also kept for the supervisor level. The block executes two kinds of return request, supervisor return and machine return, in a single clock. Each return restores the enables, picks the privilege and guest mode to resume in, and empties the saved context. When the hypervisor option is on and the hart is running as host, a supervisor return also pops the second-level stash into the first level.

The outputs are registered. A return requested in cycle N shows its result, its illegal-instruction flag and its bank-swap request after the clock edge that ends cycle N. The bank-swap pulse tells the register file outside this block to exchange guest and host copies. It is raised when a return resumes in guest mode. A load port sets up the whole state in one clock for bring-up and tests.

The load port has a single strobe and no ready signal. It is always accepted, so it can never be stalled. All other pins are plain level controls.

Top module: `trap_return_unit`

## Requirements
- R1: A supervisor return made while the privilege is user (00) changes no state. It raises `illegal_o` for exactly one cycle. `bank_swap_o` stays low.
- R2: With `hyp_present_i`=1 and `virt_o`=0, a supervisor return resumes in the privilege given by the old `sup_prev_priv` (0 means user, 1 means supervisor). It sets `virt_o` to the old `sup_prev_virt`.
- R3: On that host path, `sup_prev_virt` takes the old `sup_stash_virt`, and `sup_prev_priv` takes the old `sup_stash_priv`. Both stash bits are then cleared.
- R4: Every legal supervisor return sets `sup_prev_en` to 1. Unless R6 applies, it writes the old `sup_prev_en` into `int_en` bit 1.
- R5: When the host path does not apply (option absent, or `virt_o`=1), a legal supervisor return resumes in the old `sup_prev_priv`. It sets `sup_prev_priv` to user and leaves `virt_o` and both stash bits unchanged.
- R6: With `legacy_spec_i`=1, outside the supervisor host path, the prior-enable value is written to `int_en` bit number equal to the resume privilege (bit 0 user, bit 1 supervisor, bit 3 machine). The other `int_en` bits are left unchanged.
- R7: A machine return resumes in the old `mach_prev_priv`. It copies the old `mach_prev_en` into `int_en` bit 3 (unless R6 applies), sets `mach_prev_en` to 1, sets `mach_prev_priv` to user (00) and clears `mach_prev_virt`.
- R8: A machine return sets `virt_o` to the old `mach_prev_virt` when `hyp_present_i`=1, and leaves `virt_o` unchanged otherwise.
- R9: `bank_swap_o` pulses for one cycle after a return whose restored guest flag is 1, and at no other time.
- R10: Privilege encoding is user 00, supervisor 01, machine 11. The value 10 is never held: a load of 10 into `priv` or `mach_prev_priv` stores 00. `int_en` bit 2 always reads 0.
- R11: When both return requests arrive in one cycle, only the machine return takes effect.
- R12: A cycle with `load_valid_i`=1 writes every state field from the load inputs and overrides any return request in that cycle. The flags stay low.
- R13: After reset the privilege is machine (11) and every other state bit and flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hyp_present_i | input | 1 | Hypervisor option enabled |
| legacy_spec_i | input | 1 | Use legacy enable placement (R6) |
| sret_req_i | input | 1 | Supervisor return request |
| mret_req_i | input | 1 | Machine return request |
| load_valid_i | input | 1 | Load strobe, always accepted |
| load_priv_i | input | 2 | Load value: privilege |
| load_virt_i | input | 1 | Load value: guest flag |
| load_int_en_i | input | 4 | Load value: interrupt enables |
| load_sup_prev_en_i | input | 1 | Load value: supervisor prior enable |
| load_mach_prev_en_i | input | 1 | Load value: machine prior enable |
| load_sup_prev_priv_i | input | 1 | Load value: supervisor prior privilege |
| load_mach_prev_priv_i | input | 2 | Load value: machine prior privilege |
| load_mach_prev_virt_i | input | 1 | Load value: machine prior guest flag |
| load_sup_prev_virt_i | input | 1 | Load value: supervisor prior guest flag |
| load_sup_stash_virt_i | input | 1 | Load value: second-level guest flag |
| load_sup_stash_priv_i | input | 1 | Load value: second-level privilege |
| priv_o | output | 2 | Current privilege |
| virt_o | output | 1 | Current guest flag |
| int_en_o | output | 4 | Interrupt enables (bit 0 user, 1 supervisor, 3 machine) |
| sup_prev_en_o | output | 1 | Supervisor prior enable |
| mach_prev_en_o | output | 1 | Machine prior enable |
| sup_prev_priv_o | output | 1 | Supervisor prior privilege |
| mach_prev_priv_o | output | 2 | Machine prior privilege |
| mach_prev_virt_o | output | 1 | Machine prior guest flag |
| sup_prev_virt_o | output | 1 | Supervisor prior guest flag |
| sup_stash_virt_o | output | 1 | Second-level guest flag |
| sup_stash_priv_o | output | 1 | Second-level privilege |
| illegal_o | output | 1 | Illegal supervisor return, one-cycle pulse |
| bank_swap_o | output | 1 | Guest/host bank swap request, one-cycle pulse |

## Verification
Every state bit is a port, so a wrong field shows in the clock right after the return that produced it. No hidden state can hold a fault back for later. The error is most visible in the shift of the second-level stash and in the legacy enable position, where a wrong bit is written next to a correct one. A wrong pulse on `illegal_o` or `bank_swap_o` shows in that same cycle. A pulse that is too long shows in the idle cycle after it, and the bench checks that cycle after every return.

// File: rtl/tret_pkg.sv
package tret_pkg;

  localparam int PRIV_W   = 2;
  localparam int INT_EN_W = 4;

  typedef logic [PRIV_W-1:0] priv_t;

  localparam priv_t PRIV_U = 2'b00;
  localparam priv_t PRIV_S = 2'b01;
  localparam priv_t PRIV_M = 2'b11;

  // bit 2 of the enable vector has no owner and is held at zero
  localparam logic [INT_EN_W-1:0] INT_EN_MASK = 4'b1011;

  typedef struct packed {
    priv_t                priv;
    logic                 virt;
    logic [INT_EN_W-1:0]  int_en;
    logic                 sup_prev_en;
    logic                 mach_prev_en;
    logic                 sup_prev_priv;
    priv_t                mach_prev_priv;
    logic                 mach_prev_virt;
    logic                 sup_prev_virt;
    logic                 sup_stash_virt;
    logic                 sup_stash_priv;
  } hart_state_t;

  localparam int STATE_W = $bits(hart_state_t);

  // map the unused encoding onto user
  function automatic priv_t legal_priv(priv_t p);
    return (p == 2'b10) ? PRIV_U : p;
  endfunction

endpackage

// File: rtl/tret_ie_update.sv
module tret_ie_update
  import tret_pkg::*;
#(
  parameter int W = INT_EN_W
) (
  input  logic [W-1:0] ie_i,
  input  logic         legacy_i,
  input  priv_t        resume_priv_i,
  input  priv_t        own_priv_i,
  input  logic         value_i,
  output logic [W-1:0] ie_o
);

  priv_t sel;

  // legacy placement indexes by the level being resumed, modern by the returning level
  assign sel = legacy_i ? resume_priv_i : own_priv_i;

  for (genvar b = 0; b < W; b++) begin : g_bit
    localparam priv_t IDX = priv_t'(b);
    assign ie_o[b] = (sel == IDX) ? value_i : ie_i[b];
  end

endmodule

// File: rtl/tret_sret_calc.sv
module tret_sret_calc
  import tret_pkg::*;
(
  input  hart_state_t cur_i,
  input  logic        hyp_i,
  input  logic        legacy_i,
  output hart_state_t nxt_o,
  output logic        illegal_o,
  output logic        swap_o
);

  logic                host_path;
  priv_t               resume_priv;
  logic [INT_EN_W-1:0] ie_new;

  assign illegal_o   = (cur_i.priv == PRIV_U);
  assign host_path   = hyp_i && !cur_i.virt;
  assign resume_priv = {1'b0, cur_i.sup_prev_priv};

  tret_ie_update #(.W(INT_EN_W)) u_ie (
    .ie_i          (cur_i.int_en),
    .legacy_i      (legacy_i && !host_path),
    .resume_priv_i (resume_priv),
    .own_priv_i    (PRIV_S),
    .value_i       (cur_i.sup_prev_en),
    .ie_o          (ie_new)
  );

  always_comb begin
    nxt_o  = cur_i;
    swap_o = 1'b0;
    if (!illegal_o) begin
      nxt_o.priv        = resume_priv;
      nxt_o.int_en      = ie_new;
      nxt_o.sup_prev_en = 1'b1;
      if (host_path) begin
        // pop the second level into the first
        nxt_o.virt           = cur_i.sup_prev_virt;
        nxt_o.sup_prev_virt  = cur_i.sup_stash_virt;
        nxt_o.sup_prev_priv  = cur_i.sup_stash_priv;
        nxt_o.sup_stash_virt = 1'b0;
        nxt_o.sup_stash_priv = 1'b0;
        swap_o               = cur_i.sup_prev_virt;
      end else begin
        nxt_o.sup_prev_priv  = 1'b0;
      end
    end
  end

endmodule

// File: rtl/tret_mret_calc.sv
module tret_mret_calc
  import tret_pkg::*;
(
  input  hart_state_t cur_i,
  input  logic        hyp_i,
  input  logic        legacy_i,
  output hart_state_t nxt_o,
  output logic        swap_o
);

  logic [INT_EN_W-1:0] ie_new;

  tret_ie_update #(.W(INT_EN_W)) u_ie (
    .ie_i          (cur_i.int_en),
    .legacy_i      (legacy_i),
    .resume_priv_i (cur_i.mach_prev_priv),
    .own_priv_i    (PRIV_M),
    .value_i       (cur_i.mach_prev_en),
    .ie_o          (ie_new)
  );

  always_comb begin
    nxt_o                = cur_i;
    nxt_o.priv           = cur_i.mach_prev_priv;
    nxt_o.int_en         = ie_new;
    nxt_o.mach_prev_en   = 1'b1;
    nxt_o.mach_prev_priv = PRIV_U;
    nxt_o.mach_prev_virt = 1'b0;
    nxt_o.virt           = hyp_i ? cur_i.mach_prev_virt : cur_i.virt;
    swap_o               = hyp_i && cur_i.mach_prev_virt;
  end

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import tret_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hyp_present_i,
  input  logic        legacy_spec_i,
  input  logic        sret_req_i,
  input  logic        mret_req_i,
  input  logic        load_valid_i,
  input  logic [1:0]  load_priv_i,
  input  logic        load_virt_i,
  input  logic [3:0]  load_int_en_i,
  input  logic        load_sup_prev_en_i,
  input  logic        load_mach_prev_en_i,
  input  logic        load_sup_prev_priv_i,
  input  logic [1:0]  load_mach_prev_priv_i,
  input  logic        load_mach_prev_virt_i,
  input  logic        load_sup_prev_virt_i,
  input  logic        load_sup_stash_virt_i,
  input  logic        load_sup_stash_priv_i,
  output logic [1:0]  priv_o,
  output logic        virt_o,
  output logic [3:0]  int_en_o,
  output logic        sup_prev_en_o,
  output logic        mach_prev_en_o,
  output logic        sup_prev_priv_o,
  output logic [1:0]  mach_prev_priv_o,
  output logic        mach_prev_virt_o,
  output logic        sup_prev_virt_o,
  output logic        sup_stash_virt_o,
  output logic        sup_stash_priv_o,
  output logic        illegal_o,
  output logic        bank_swap_o
);

  localparam hart_state_t RESET_STATE = '{priv: PRIV_M, default: '0};

  hart_state_t state_q, state_d, load_state, sret_nxt, mret_nxt;
  logic        sret_ill, sret_swap, mret_swap;
  logic        illegal_d, swap_d, illegal_q, swap_q;

  always_comb begin
    load_state.priv           = legal_priv(load_priv_i);
    load_state.virt           = load_virt_i;
    load_state.int_en         = load_int_en_i & INT_EN_MASK;
    load_state.sup_prev_en    = load_sup_prev_en_i;
    load_state.mach_prev_en   = load_mach_prev_en_i;
    load_state.sup_prev_priv  = load_sup_prev_priv_i;
    load_state.mach_prev_priv = legal_priv(load_mach_prev_priv_i);
    load_state.mach_prev_virt = load_mach_prev_virt_i;
    load_state.sup_prev_virt  = load_sup_prev_virt_i;
    load_state.sup_stash_virt = load_sup_stash_virt_i;
    load_state.sup_stash_priv = load_sup_stash_priv_i;
  end

  tret_sret_calc u_sret (
    .cur_i     (state_q),
    .hyp_i     (hyp_present_i),
    .legacy_i  (legacy_spec_i),
    .nxt_o     (sret_nxt),
    .illegal_o (sret_ill),
    .swap_o    (sret_swap)
  );

  tret_mret_calc u_mret (
    .cur_i    (state_q),
    .hyp_i    (hyp_present_i),
    .legacy_i (legacy_spec_i),
    .nxt_o    (mret_nxt),
    .swap_o   (mret_swap)
  );

  // load over machine return over supervisor return
  always_comb begin
    state_d   = state_q;
    illegal_d = 1'b0;
    swap_d    = 1'b0;
    if (load_valid_i) begin
      state_d = load_state;
    end else if (mret_req_i) begin
      state_d = mret_nxt;
      swap_d  = mret_swap;
    end else if (sret_req_i) begin
      state_d   = sret_nxt;
      illegal_d = sret_ill;
      swap_d    = sret_swap;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= RESET_STATE;
      illegal_q <= 1'b0;
      swap_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      illegal_q <= illegal_d;
      swap_q    <= swap_d;
    end
  end

  assign priv_o           = state_q.priv;
  assign virt_o           = state_q.virt;
  assign int_en_o         = state_q.int_en;
  assign sup_prev_en_o    = state_q.sup_prev_en;
  assign mach_prev_en_o   = state_q.mach_prev_en;
  assign sup_prev_priv_o  = state_q.sup_prev_priv;
  assign mach_prev_priv_o = state_q.mach_prev_priv;
  assign mach_prev_virt_o = state_q.mach_prev_virt;
  assign sup_prev_virt_o  = state_q.sup_prev_virt;
  assign sup_stash_virt_o = state_q.sup_stash_virt;
  assign sup_stash_priv_o = state_q.sup_stash_priv;
  assign illegal_o        = illegal_q;
  assign bank_swap_o      = swap_q;

  p_illegal_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_q |-> (state_q == $past(state_q)));

  p_host_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_valid_i && !mret_req_i && sret_req_i && state_q.priv != PRIV_U
     && hyp_present_i && !state_q.virt)
    |=> (!state_q.sup_stash_virt && !state_q.sup_stash_priv));

  p_sret_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_valid_i && !mret_req_i && sret_req_i && state_q.priv != PRIV_U)
    |=> state_q.sup_prev_en);

  p_mret_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_valid_i && mret_req_i)
    |=> (state_q.mach_prev_priv == PRIV_U && !state_q.mach_prev_virt && state_q.mach_prev_en));

  p_swap_guest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    swap_q |-> state_q.virt);

  p_priv_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q.priv != 2'b10) && (state_q.mach_prev_priv != 2'b10) && !state_q.int_en[2]);

  p_load_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid_i |=> (!illegal_q && !swap_q));

endmodule

// File: tb/trap_return_unit_tb_top.sv
module trap_return_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NV         = 12;

  // {hyp, legacy, sret, mret, start[15:0], expect[15:0], ill, swap}
  // state field order: priv(2) virt int_en(4) sup_prev_en mach_prev_en sup_prev_priv
  //                    mach_prev_priv(2) mach_prev_virt sup_prev_virt sup_stash_virt sup_stash_priv
  localparam logic [37:0] VEC [NV] = '{
    // R2 R3 R4 R9 host pop, resume guest
    {4'b1010, 16'b01_0_0000_1_0_1_00_0_1_0_1, 16'b01_1_0010_1_0_1_00_0_0_0_0, 2'b01},
    // R2 R3 R4 host pop from machine, stay host
    {4'b1010, 16'b11_0_1010_0_1_0_11_1_0_1_0, 16'b00_0_1000_1_1_0_11_1_1_0_0, 2'b00},
    // R4 R5 option absent
    {4'b0010, 16'b01_0_0000_1_0_1_00_0_1_1_1, 16'b01_0_0010_1_0_0_00_0_1_1_1, 2'b00},
    // R5 option present but guest running
    {4'b1010, 16'b01_1_0010_0_0_0_00_0_1_1_0, 16'b00_1_0000_1_0_0_00_0_1_1_0, 2'b00},
    // R1 supervisor return from user
    {4'b1010, 16'b00_0_0011_1_1_1_11_1_1_1_1, 16'b00_0_0011_1_1_1_11_1_1_1_1, 2'b10},
    // R6 legacy, resume user -> bit 0
    {4'b0110, 16'b11_0_0000_1_0_0_00_0_0_0_0, 16'b00_0_0001_1_0_0_00_0_0_0_0, 2'b00},
    // R6 legacy, resume supervisor -> bit 1 cleared only
    {4'b0110, 16'b01_0_1011_0_0_1_00_0_0_0_0, 16'b01_0_1001_1_0_0_00_0_0_0_0, 2'b00},
    // R7 R8 R9 machine return into guest
    {4'b1001, 16'b11_0_0000_0_1_0_01_1_0_0_0, 16'b01_1_1000_0_1_0_00_0_0_0_0, 2'b01},
    // R7 R8 option absent keeps guest flag
    {4'b0001, 16'b11_0_1010_0_0_0_11_1_0_0_0, 16'b11_0_0010_0_1_0_00_0_0_0_0, 2'b00},
    // R6 R7 legacy machine return into supervisor -> bit 1
    {4'b0101, 16'b11_0_0000_0_1_0_01_0_0_0_0, 16'b01_0_0010_0_1_0_00_0_0_0_0, 2'b00},
    // R11 both requests, machine wins
    {4'b1011, 16'b11_0_0000_1_0_1_00_0_1_1_1, 16'b00_0_0000_1_1_1_00_0_1_1_1, 2'b00},
    // R8 machine return drops guest flag, no swap
    {4'b1001, 16'b11_1_0000_0_0_0_00_0_0_0_0, 16'b00_0_0000_0_1_0_00_0_0_0_0, 2'b00}
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R2 R3 R4 R9";
      1: return "R2 R3 R4";
      2: return "R4 R5";
      3: return "R5";
      4: return "R1";
      5, 6: return "R6";
      7: return "R7 R8 R9";
      8: return "R7 R8";
      9: return "R6 R7";
      10: return "R11";
      default: return "R8";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n;
  logic hyp, legacy, sret, mret, load_v;
  logic [15:0] load_s;
  logic [1:0]  priv;
  logic        virt, spe, mpe, spp, mpv, spv, ssv, ssp, ill, swap;
  logic [3:0]  ie;
  logic [1:0]  mpp;
  logic [15:0] obs;
  int n_checks = 0;
  int n_err    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign obs = {priv, virt, ie, spe, mpe, spp, mpp, mpv, spv, ssv, ssp};

  trap_return_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .hyp_present_i(hyp), .legacy_spec_i(legacy),
    .sret_req_i(sret), .mret_req_i(mret),
    .load_valid_i(load_v),
    .load_priv_i(load_s[15:14]), .load_virt_i(load_s[13]), .load_int_en_i(load_s[12:9]),
    .load_sup_prev_en_i(load_s[8]), .load_mach_prev_en_i(load_s[7]),
    .load_sup_prev_priv_i(load_s[6]), .load_mach_prev_priv_i(load_s[5:4]),
    .load_mach_prev_virt_i(load_s[3]), .load_sup_prev_virt_i(load_s[2]),
    .load_sup_stash_virt_i(load_s[1]), .load_sup_stash_priv_i(load_s[0]),
    .priv_o(priv), .virt_o(virt), .int_en_o(ie),
    .sup_prev_en_o(spe), .mach_prev_en_o(mpe), .sup_prev_priv_o(spp),
    .mach_prev_priv_o(mpp), .mach_prev_virt_o(mpv), .sup_prev_virt_o(spv),
    .sup_stash_virt_o(ssv), .sup_stash_priv_o(ssp),
    .illegal_o(ill), .bank_swap_o(swap)
  );

  task automatic check(string req, logic [17:0] act, logic [17:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_err++;
    $display("FAIL watchdog all-requirements actual=cycle-limit expected=run-complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; hyp = 0; legacy = 0; sret = 0; mret = 0; load_v = 0; load_s = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state
    check("R13", {obs, ill, swap}, {16'b11_0_0000_0_0_0_00_0_0_0_0, 2'b00});

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      load_v = 1'b1; load_s = VEC[i][33:18];
      @(negedge clk);
      // R12 load takes effect in one clock, flags low
      check("R12", {obs, ill, swap}, {VEC[i][33:18], 2'b00});
      load_v = 1'b0;
      hyp = VEC[i][37]; legacy = VEC[i][36]; sret = VEC[i][35]; mret = VEC[i][34];
      @(negedge clk);
      check(vtag(i), {obs, ill, swap}, {VEC[i][17:2], VEC[i][1:0]});
      sret = 1'b0; mret = 1'b0;
      @(negedge clk);
      // R1 R9 pulses last one cycle, state holds while idle
      check("R1 R9 pulse end", {obs, ill, swap}, {VEC[i][17:2], 2'b00});
    end

    // R10 reserved privilege code and enable bit 2 on load
    @(negedge clk);
    load_v = 1'b1; load_s = 16'b10_0_0100_0_0_0_10_0_0_0_0;
    @(negedge clk);
    check("R10", {obs, ill, swap}, {16'b00_0_0000_0_0_0_00_0_0_0_0, 2'b00});

    // R12 load beats a return in the same cycle
    load_s = 16'b01_0_0000_1_0_1_00_0_0_0_0; sret = 1'b1; mret = 1'b0; hyp = 1'b0;
    @(negedge clk);
    check("R12 priority", {obs, ill, swap}, {16'b01_0_0000_1_0_1_00_0_0_0_0, 2'b00});
    load_v = 1'b0; sret = 1'b0;

    // R13 reset again from a non-reset state
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R13 re-reset", {obs, ill, swap}, {16'b11_0_0000_0_0_0_00_0_0_0_0, 2'b00});

    finish_run();
  end

endmodule